// File: doc/BRIEF.md
# Vector Shift-Right-and-Merge Execution Unit

This unit executes one SIMD instruction: every lane of a source vector is shifted right by an immediate amount, and the shifted bits are merged into the matching lane of the current destination vector. The top bits of the destination lane, which the shift leaves empty, keep their old values. Lane width and shift count are packed together into one variable-length size field of the instruction word. The unit decodes both from that field and handles every lane of the vector at the same time.

The surrounding datapath presents a 32-bit instruction word, the source vector and the current destination vector with a one-cycle strobe. One cycle later the unit returns the new destination vector with a valid flag. It raises an undefined-instruction flag for the reserved size encoding. Words that do not carry this instruction's fixed opcode bits are ignored. The vector width is an elaboration parameter. Timing never depends on the operand data.

Top module: `vsri_unit`

## Requirements
- R1: An instruction word belongs to the unit only when bits [31:24] equal 8'h45, bit [21] is 0 and bits [15:10] equal 6'b111100.
- R2: A strobed matching word whose 4-bit size field {bits[23:22], bits[20:19]} is 0000 sets `out_undef` high and `out_valid` low one cycle later, and leaves `out_vec` unchanged.
- R3: A strobed word that fails the R1 match sets neither `out_valid` nor `out_undef` and leaves `out_vec` unchanged.
- R4: Lane width comes from the highest set bit of the size field: 0001 gives 8 bits, 001x gives 16, 01xx gives 32 and 1xxx gives 64.
- R5: The shift count is twice the lane width minus the unsigned value of the 7-bit field {bits[23:22], bits[20:19], bits[18:16]}, which gives a count from 1 up to the lane width.
- R6: Each result lane equals (old destination lane AND NOT (all-ones >> shift)) OR (source lane >> shift), using logical shifts.
- R7: A shift equal to the full lane width returns the destination lane unchanged. The count is not wrapped modulo the lane width.
- R8: `out_valid` rises exactly one cycle after a strobed legal word, whatever the operand data. Words strobed on back-to-back cycles each give a result on the following cycle.
- R9: After synchronous reset, `out_valid`, `out_undef`, `out_vec` and both index outputs are zero.
- R10: With each valid result, `out_rd_idx` carries bits [4:0] and `out_rs_idx` carries bits [9:5] of the instruction that produced it.
- R11: Every lane of a vector of VLEN bits (a multiple of 64, default 128) is processed, with no predication.
- R12: When no legal word is strobed, `out_vec` and the index outputs hold their last values and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe for the instruction and operands |
| instr | input | 32 | Instruction word |
| src_vec | input | VLEN | Source vector |
| dst_vec | input | VLEN | Current destination vector |
| out_valid | output | 1 | New destination vector is ready |
| out_undef | output | 1 | Reserved size encoding seen |
| out_vec | output | VLEN | New destination vector |
| out_rd_idx | output | 5 | Destination register index of the result |
| out_rs_idx | output | 5 | Source register index of the result |

## Verification
All results (`out_valid`, `out_undef`, `out_vec` and the indices) are due in the cycle after the strobe edge, since there is exactly one register stage. The bench drives each word on a falling edge. It compares every output on the next falling edge, after that single rising edge, against a bit-by-bit model. When words are streamed on consecutive cycles, the comparison for word k takes place on the same falling edge where word k+1 is driven, so every result is checked in the one cycle it belongs to.

// File: rtl/vsri_pkg.sv
`timescale 1ns/1ps
package vsri_pkg;

  // lane width as log2 of the byte count
  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_w_e;

  localparam int CHUNK_W   = 64;
  localparam int SHAMT_W   = 7;
  localparam int REGIDX_W  = 5;

  localparam logic [7:0] OPC_HI   = 8'h45;
  localparam logic [5:0] OPC_MID  = 6'b111100;

  typedef struct packed {
    logic          hit;
    logic          reserved;
    lane_w_e       lw;
    logic [SHAMT_W-1:0] shamt;
  } dec_t;

endpackage

// File: rtl/vsri_decode.sv
`timescale 1ns/1ps
module vsri_decode
  import vsri_pkg::*;
(
  input  logic [31:10] word,
  output dec_t         dec
);

  logic [3:0]         szf;
  logic [2:0]         fine;
  logic [SHAMT_W-1:0] twice_w;
  lane_w_e            lw;

  assign szf  = {word[23:22], word[20:19]};
  assign fine = word[18:16];

  // highest set bit of the size field picks the lane width
  always_comb begin
    casez (szf)
      4'b1???: lw = LW_64;
      4'b01??: lw = LW_32;
      4'b001?: lw = LW_16;
      default: lw = LW_8;
    endcase
  end

  // twice the lane width, modulo 128 (128 wraps to 0, which still
  // yields 128 - value for the 64-bit case in 7-bit arithmetic)
  always_comb begin
    case (lw)
      LW_8:    twice_w = 7'd16;
      LW_16:   twice_w = 7'd32;
      LW_32:   twice_w = 7'd64;
      default: twice_w = 7'd0;
    endcase
  end

  always_comb begin
    dec.hit      = (word[31:24] == OPC_HI) && !word[21] && (word[15:10] == OPC_MID);
    dec.reserved = (szf == 4'b0000);
    dec.lw       = lw;
    dec.shamt    = twice_w - {szf, fine};
  end

endmodule

// File: rtl/vsri_lane.sv
`timescale 1ns/1ps
module vsri_lane
  import vsri_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]       old_lane,
  input  logic [W-1:0]       src_lane,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [W-1:0]       new_lane
);

  localparam logic [SHAMT_W:0] W_LIM = (SHAMT_W+1)'(W);

  logic           full;
  logic [W-1:0]   keep_n;
  logic [W-1:0]   moved;

  // a count at or beyond the lane width empties both terms; no wrap
  assign full   = ({1'b0, shamt} >= W_LIM);
  assign keep_n = full ? '0 : ({W{1'b1}} >> shamt);
  assign moved  = full ? '0 : (src_lane >> shamt);

  assign new_lane = (old_lane & ~keep_n) | moved;

endmodule

// File: rtl/vsri_chunk.sv
`timescale 1ns/1ps
module vsri_chunk
  import vsri_pkg::*;
(
  input  logic [CHUNK_W-1:0] old_c,
  input  logic [CHUNK_W-1:0] src_c,
  input  lane_w_e            lw,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [CHUNK_W-1:0] new_c
);

  localparam int N_FAM = 4;

  logic [CHUNK_W-1:0] fam_res [N_FAM];

  for (genvar g = 0; g < N_FAM; g++) begin : g_fam
    localparam int LW_BITS = 8 << g;
    localparam int N_LANE  = CHUNK_W / LW_BITS;
    logic [CHUNK_W-1:0] res_g;

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
      vsri_lane #(.W(LW_BITS)) u_lane (
        .old_lane (old_c[l*LW_BITS +: LW_BITS]),
        .src_lane (src_c[l*LW_BITS +: LW_BITS]),
        .shamt    (shamt),
        .new_lane (res_g[l*LW_BITS +: LW_BITS])
      );
    end

    assign fam_res[g] = res_g;
  end

  assign new_c = fam_res[lw];

endmodule

// File: rtl/vsri_unit.sv
`timescale 1ns/1ps
module vsri_unit
  import vsri_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [31:0]         instr,
  input  logic [VLEN-1:0]     src_vec,
  input  logic [VLEN-1:0]     dst_vec,
  output logic                out_valid,
  output logic                out_undef,
  output logic [VLEN-1:0]     out_vec,
  output logic [REGIDX_W-1:0] out_rd_idx,
  output logic [REGIDX_W-1:0] out_rs_idx
);

  localparam int N_CHUNK = VLEN / CHUNK_W;

  initial begin
    if ((VLEN % CHUNK_W) != 0 || VLEN < CHUNK_W)
      $error("vsri_unit: VLEN must be a positive multiple of 64");
  end

  dec_t            dec;
  logic [VLEN-1:0] merged;
  logic            fire;
  logic            trap;

  vsri_decode u_dec (
    .word (instr[31:10]),
    .dec  (dec)
  );

  for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
    vsri_chunk u_chunk (
      .old_c (dst_vec[c*CHUNK_W +: CHUNK_W]),
      .src_c (src_vec[c*CHUNK_W +: CHUNK_W]),
      .lw    (dec.lw),
      .shamt (dec.shamt),
      .new_c (merged[c*CHUNK_W +: CHUNK_W])
    );
  end

  assign fire = in_valid && dec.hit && !dec.reserved;
  assign trap = in_valid && dec.hit &&  dec.reserved;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_undef  <= 1'b0;
      out_vec    <= '0;
      out_rd_idx <= '0;
      out_rs_idx <= '0;
    end else begin
      out_valid <= fire;
      out_undef <= trap;
      if (fire) begin
        out_vec    <= merged;
        out_rd_idx <= instr[4:0];
        out_rs_idx <= instr[9:5];
      end
    end
  end

endmodule

// File: rtl/vsri_unit_chk.sv
`timescale 1ns/1ps
module vsri_unit_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic [VLEN-1:0] src_vec,
  input logic [VLEN-1:0] dst_vec,
  input logic            out_valid,
  input logic            out_undef,
  input logic [VLEN-1:0] out_vec,
  input logic [4:0]      out_rd_idx,
  input logic [4:0]      out_rs_idx
);

  logic       opc_ok;
  logic [3:0] szf;
  logic       legal;
  logic       full_shift;

  assign opc_ok     = (instr[31:24] == 8'h45) && !instr[21] && (instr[15:10] == 6'b111100);
  assign szf        = {instr[23:22], instr[20:19]};
  assign legal      = in_valid && opc_ok && (szf != 4'd0);
  assign full_shift = $onehot(szf) && (instr[18:16] == 3'd0);

  assert_flags_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, out_undef}));

  assert_undef_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_ok && szf == 4'd0) |=> (out_undef && !out_valid && $stable(out_vec)));

  assert_foreign_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !opc_ok) |=> (!out_valid && !out_undef && $stable(out_vec)));

  assert_full_shift_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (legal && full_shift) |=> (out_vec == $past(dst_vec)));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    legal |=> out_valid);

  assert_valid_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(legal));

  assert_idx_echo_R10: assert property (@(posedge clk) disable iff (rst)
    legal |=> (out_rd_idx == $past(instr[4:0]) && out_rs_idx == $past(instr[9:5])));

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !legal |=> ($stable(out_vec) && $stable(out_rd_idx) && $stable(out_rs_idx)));

  logic unused_src;
  assign unused_src = ^src_vec;

endmodule

bind vsri_unit vsri_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .instr      (instr),
  .src_vec    (src_vec),
  .dst_vec    (dst_vec),
  .out_valid  (out_valid),
  .out_undef  (out_undef),
  .out_vec    (out_vec),
  .out_rd_idx (out_rd_idx),
  .out_rs_idx (out_rs_idx)
);

// File: tb/vsri_unit_test.sv
`timescale 1ns/1ps
module vsri_unit_test;

  localparam int VLEN = 128;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [31:0]     instr;
  logic [VLEN-1:0] src_vec;
  logic [VLEN-1:0] dst_vec;
  logic            out_valid;
  logic            out_undef;
  logic [VLEN-1:0] out_vec;
  logic [4:0]      out_rd_idx;
  logic [4:0]      out_rs_idx;

  int checks = 0;
  int fails  = 0;

  // model state
  logic            e_valid, e_undef;
  logic [VLEN-1:0] e_vec;
  logic [4:0]      e_rd, e_rs;

  always #2.5 clk = ~clk;

  vsri_unit #(.VLEN(VLEN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_vec(src_vec), .dst_vec(dst_vec), .out_valid(out_valid),
    .out_undef(out_undef), .out_vec(out_vec),
    .out_rd_idx(out_rd_idx), .out_rs_idx(out_rs_idx)
  );

  task automatic chk(input bit ok, input string tag, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [31:0] mk(input int lw_log, input int sh,
                                     input logic [4:0] rn, input logic [4:0] rd);
    logic [6:0] code;
    code = 7'((16 << lw_log) - sh);
    return {8'h45, code[6:5], 1'b0, code[4:3], code[2:0], 6'b111100, rn, rd};
  endfunction

  // bit-level reference: lane bit b takes src bit b+sh, or keeps dst
  // when b+sh falls off the top of the lane (R4 R5 R6 R7)
  function automatic logic [VLEN-1:0] ref_merge(input logic [31:0] w,
      input logic [VLEN-1:0] s, input logic [VLEN-1:0] d);
    logic [3:0] z;
    int es, sh;
    logic [VLEN-1:0] r;
    z = {w[23:22], w[20:19]};
    if (z[3]) es = 64; else if (z[2]) es = 32; else if (z[1]) es = 16; else es = 8;
    sh = 2*es - int'({z, w[18:16]});
    r = d;
    for (int e = 0; e < VLEN/es; e++)
      for (int b = 0; b < es; b++)
        if (b + sh < es) r[e*es + b] = s[e*es + b + sh];
    return r;
  endfunction

  // drive on this falling edge, compare on the next
  task automatic step(input logic v, input logic [31:0] w, input logic [VLEN-1:0] s,
                      input logic [VLEN-1:0] d, input string tag);
    bit opc, fire;
    opc  = (w[31:24] == 8'h45) && !w[21] && (w[15:10] == 6'b111100);
    fire = v && opc && ({w[23:22], w[20:19]} != 4'd0);
    in_valid = v; instr = w; src_vec = s; dst_vec = d;
    e_valid = fire;
    e_undef = v && opc && !fire;
    if (fire) begin
      e_vec = ref_merge(w, s, d);
      e_rd  = w[4:0];
      e_rs  = w[9:5];
    end
    @(negedge clk);
    chk(out_valid == e_valid, {tag, " R8 out_valid"}, VLEN'(out_valid), VLEN'(e_valid));
    chk(out_undef == e_undef, {tag, " R2 out_undef"}, VLEN'(out_undef), VLEN'(e_undef));
    chk(out_vec == e_vec, {tag, " R6 out_vec"}, out_vec, e_vec);
    chk(out_rd_idx == e_rd && out_rs_idx == e_rs, {tag, " R10 idx"},
        VLEN'({out_rs_idx, out_rd_idx}), VLEN'({e_rs, e_rd}));
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [VLEN-1:0] s, d;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; instr = '0; src_vec = '0; dst_vec = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(!out_valid && !out_undef, "R9 reset flags", VLEN'({out_valid, out_undef}), '0);
    chk(out_vec == '0 && out_rd_idx == 0 && out_rs_idx == 0, "R9 reset data", out_vec, '0);
    e_valid = 0; e_undef = 0; e_vec = '0; e_rd = '0; e_rs = '0;

    // R4 R5 R6 R11: every lane width, every legal shift
    for (int lg = 0; lg < 4; lg++)
      for (int sh = 1; sh <= (8 << lg); sh++)
        step(1'b1, mk(lg, sh, 5'($urandom), 5'($urandom)), rnd_vec(), rnd_vec(), "R4 R5 sweep");

    // R7: full-width shift keeps destination, with all-ones source
    for (int lg = 0; lg < 4; lg++) begin
      d = rnd_vec();
      step(1'b1, mk(lg, 8 << lg, 5'd3, 5'd9), '1, d, "R7 full");
      chk(out_vec == d, "R7 full-width keeps dst", out_vec, d);
    end
    // shift by one: top bit of each lane from dst
    step(1'b1, mk(0, 1, 5'd1, 5'd2), '1, '0, "R6 shift1");
    chk(out_vec == {(VLEN/8){8'h7F}}, "R6 byte shift1", out_vec, {(VLEN/8){8'h7F}});

    // R2 reserved size field
    for (int f = 0; f < 8; f++) begin
      s = out_vec;
      step(1'b1, {8'h45, 2'b00, 1'b0, 2'b00, 3'(f), 6'b111100, 10'h155}, rnd_vec(), rnd_vec(), "R2 reserved");
      chk(out_vec == s, "R2 vec unchanged", out_vec, s);
    end

    // R1 R3: one fixed bit flipped at a time
    for (int b = 0; b < 32; b++) begin
      if ((b >= 24) || b == 21 || (b >= 10 && b <= 15)) begin
        s = out_vec;
        step(1'b1, mk(2, 5, 5'd7, 5'd8) ^ (32'd1 << b), rnd_vec(), rnd_vec(), "R1 R3 foreign");
        chk(out_vec == s && !out_valid && !out_undef, "R3 foreign ignored", out_vec, s);
      end
    end

    // R12: legal word without strobe
    s = out_vec;
    step(1'b1, mk(1, 3, 5'd4, 5'd5), rnd_vec(), rnd_vec(), "R12 prime");
    s = out_vec;
    step(1'b0, mk(3, 7, 5'd6, 5'd1), rnd_vec(), rnd_vec(), "R12 idle");
    chk(out_vec == s && !out_valid, "R12 hold", out_vec, s);

    // R8 R11: back-to-back mixed stream
    for (int k = 0; k < 300; k++) begin
      int lg, sh;
      logic [31:0] w;
      lg = int'($urandom % 4);
      sh = 1 + int'($urandom % (8 << lg));
      w  = mk(lg, sh, 5'($urandom), 5'($urandom));
      if ($urandom % 10 == 0) w[23:19] = 5'b00000;
      if ($urandom % 10 == 0) w[31] = 1'b1;
      step(1'($urandom % 4 != 0), w, rnd_vec(), rnd_vec(), "R8 R11 stream");
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule